// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low-order address bits for a four-beat memory burst. When either of two active-low start strobes is sampled low at a rising clock edge, the block latches three things: the full incoming word address, the two lowest address bits as the burst's starting beat, and the order selection. Each later edge at which the active-low advance input is low moves the burst address to the next beat. The order is either interleaved or linear.

The interleaved order is the starting value XOR a beat count that counts up by one on each advance. The linear order is the starting value plus the beat count, modulo four. The word address on the output is the latched upper bits with the sequenced low bits appended. The block has no data path, so every pin is a plain control or address pin and there is no valid/ready interface.

The state sits in registers. The outputs are a combinational map of that state, so a change taken at edge N shows on the outputs right after edge N.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first load, `burst_lo` is 00 and `word_addr` is all zeros. The stored order is interleaved and the beat count is zero.
- R2: If `strb_a_n` or `strb_b_n` is low at a rising edge, `burst_lo` takes `addr_in[1:0]` and `word_addr[ADDR_W-1:2]` takes `addr_in[ADDR_W-1:2]` right after that edge. Both strobes low at once acts as a single load.
- R3: With no strobe low, an edge with `adv_n` high leaves `burst_lo` and `word_addr` unchanged.
- R4: When the stored order is interleaved (`order_lin` = 0 at load), the beats for starts 00, 01, 10 and 11 are 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00. That is, start XOR beat count.
- R5: When the stored order is linear (`order_lin` = 1 at load), each advance adds one to `burst_lo` and wraps from 11 to 00.
- R6: `adv_n` has no effect at an edge where a load takes place: `burst_lo` equals the new start value.
- R7: `order_lin` is sampled only at a load. Changing it during the burst does not change the sequence.
- R8: After four advances the burst address returns to the start value in both orders, and the sequence repeats.
- R9: With no strobe low, changes on `addr_in` have no effect on `word_addr` or `burst_lo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strb_a_n | input | 1 | Active-low start strobe, first source |
| strb_b_n | input | 1 | Active-low start strobe, second source |
| adv_n | input | 1 | Active-low beat advance |
| order_lin | input | 1 | Order select at load: 1 linear, 0 interleaved |
| addr_in | input | ADDR_W | Word address presented with a strobe |
| burst_lo | output | BEAT_W | Current burst beat address |
| word_addr | output | ADDR_W | Latched upper bits joined with `burst_lo` |

## Verification
Directed bursts from every start value, four and more advances long, run in both orders. These separate an XOR map from an adder map and show the wrap back to the start. Other patterns target specific behaviours:
- A load with `adv_n` low shows whether the advance is wrongly honoured during a load.
- Flipping `order_lin` in the middle of a burst shows whether the order is re-sampled.
- Loading through each strobe alone, and through both together, tests the load logic.
- Idle cycles with a changing `addr_in` test the holding of the latched address.

A long random run then mixes strobes, advances and mode flips, and compares the outputs with a reference model in the bench.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } order_e;
endpackage

// File: rtl/burst_start_ctl.sv
`timescale 1ns/1ps
// Captures the start address and order selection when a burst begins.
module burst_start_ctl
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strb_a_n,
  input  logic                     strb_b_n,
  input  logic                     order_lin,
  input  logic [ADDR_W-1:0]        addr_in,
  output logic                     load,
  output logic [BEAT_W-1:0]        start_q,
  output logic [ADDR_W-BEAT_W-1:0] upper_q,
  output order_e                   order_q
);
  localparam int UP_W = ADDR_W - BEAT_W;

  assign load = ~strb_a_n | ~strb_b_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      upper_q <= '0;
      order_q <= ORD_INTERLEAVE;
    end else if (load) begin
      start_q <= addr_in[BEAT_W-1:0];
      upper_q <= addr_in[ADDR_W-1 -: UP_W];
      order_q <= order_lin ? ORD_LINEAR : ORD_INTERLEAVE;
    end
  end
endmodule

// File: rtl/burst_beat_ctr.sv
`timescale 1ns/1ps
// Counts the beats taken since the load; a load clears it and wins over an advance.
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv_n,
  output logic [BEAT_W-1:0] beat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       beat_q <= '0;
    else if (load)    beat_q <= '0;
    else if (!adv_n)  beat_q <= beat_q + 1'b1;
  end
endmodule

// File: rtl/burst_order_map.sv
`timescale 1ns/1ps
// Maps the start value and beat count to a beat address in the selected order.
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_q,
  input  logic [BEAT_W-1:0] beat_q,
  input  order_e            order_q,
  output logic [BEAT_W-1:0] beat_addr
);
  logic [BEAT_W-1:0] ilv;
  logic [BEAT_W-1:0] lin;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv[b] = start_q[b] ^ beat_q[b];
  end

  assign lin = start_q + beat_q;

  always_comb begin
    unique case (order_q)
      ORD_LINEAR:     beat_addr = lin;
      default:        beat_addr = ilv;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_a_n,
  input  logic              strb_b_n,
  input  logic              adv_n,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [BEAT_W-1:0] burst_lo,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              load;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [UP_W-1:0]   upper_q;
  order_e            order_q;
  logic              order_is_lin;

  burst_start_ctl #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_start (
    .clk(clk), .rst_n(rst_n), .strb_a_n(strb_a_n), .strb_b_n(strb_b_n),
    .order_lin(order_lin), .addr_in(addr_in), .load(load),
    .start_q(start_q), .upper_q(upper_q), .order_q(order_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .load(load), .adv_n(adv_n), .beat_q(beat_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_q(start_q), .beat_q(beat_q), .order_q(order_q), .beat_addr(burst_lo)
  );

  assign order_is_lin = (order_q == ORD_LINEAR);
  assign word_addr    = {upper_q, burst_lo};
endmodule

// File: rtl/burst_addr_seq_chk.sv
`timescale 1ns/1ps
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strb_a_n,
  input logic              strb_b_n,
  input logic              adv_n,
  input logic              order_is_lin,
  input logic [ADDR_W-1:0] addr_in,
  input logic [BEAT_W-1:0] burst_lo,
  input logic [ADDR_W-1:0] word_addr
);
  logic ld;
  assign ld = !strb_a_n || !strb_b_n;

  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (burst_lo == $past(addr_in[BEAT_W-1:0])) && (word_addr == $past(addr_in)));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && adv_n) |=> $stable(burst_lo) && $stable(word_addr));

  a_r9_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv_n && order_is_lin) |=> burst_lo == BEAT_W'($past(burst_lo) + 1'b1));

  a_r4_ilv_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv_n && !order_is_lin) |=> burst_lo != $past(burst_lo));

  a_r7_order_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(order_is_lin));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strb_a_n(strb_a_n), .strb_b_n(strb_b_n),
  .adv_n(adv_n), .order_is_lin(order_is_lin), .addr_in(addr_in),
  .burst_lo(burst_lo), .word_addr(word_addr)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strb_a_n = 1'b1, strb_b_n = 1'b1, adv_n = 1'b1, order_lin = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [1:0]    burst_lo;
  logic [AW-1:0] word_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [1:0]    m_start = 2'b00;
  logic [1:0]    m_beat  = 2'b00;
  logic          m_lin   = 1'b0;
  logic [AW-3:0] m_upper = '0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .strb_a_n(strb_a_n), .strb_b_n(strb_b_n),
    .adv_n(adv_n), .order_lin(order_lin), .addr_in(addr_in),
    .burst_lo(burst_lo), .word_addr(word_addr)
  );

  // Interleaved table written out from R4
  function automatic logic [1:0] ilv_tbl(input logic [1:0] s, input logic [1:0] k);
    logic [7:0] row;
    case (s)
      2'd0: row = {2'b00, 2'b01, 2'b10, 2'b11};
      2'd1: row = {2'b01, 2'b00, 2'b11, 2'b10};
      2'd2: row = {2'b10, 2'b11, 2'b00, 2'b01};
      default: row = {2'b11, 2'b10, 2'b01, 2'b00};
    endcase
    return row[7 - 2*k -: 2];
  endfunction

  function automatic logic [1:0] exp_lo();
    if (m_lin) return 2'((m_start + m_beat) % 4);
    return ilv_tbl(m_start, m_beat);
  endfunction

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, update the model, check after the rising edge.
  task automatic cyc(input bit sa, input bit sb, input bit adv, input bit lin,
                     input logic [AW-1:0] a, input string req);
    logic [AW-1:0] e;
    @(negedge clk);
    strb_a_n = sa; strb_b_n = sb; adv_n = adv; order_lin = lin; addr_in = a;
    @(posedge clk);
    if (!sa || !sb) begin
      m_start = a[1:0]; m_upper = a[AW-1:2]; m_beat = 2'b00; m_lin = lin;
    end else if (!adv) begin
      m_beat = m_beat + 2'b01;
    end
    #2;
    e = {m_upper, exp_lo()};
    check(burst_lo == e[1:0] && word_addr == e, req, word_addr, e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #2;
    check(burst_lo == 2'b00 && word_addr == '0, "R1", word_addr, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check(burst_lo == 2'b00 && word_addr == '0, "R1", word_addr, '0);

    // R4 and R8: every start value, interleaved order, five advances
    for (int s = 0; s < 4; s++) begin
      cyc(1'b0, 1'b1, 1'b1, 1'b0, AW'(17'h1A5F0 | s), "R2");
      for (int k = 0; k < 5; k++) cyc(1'b1, 1'b1, 1'b0, 1'b0, '0, k == 3 ? "R8" : "R4");
    end
    // R5 and R8: every start value, linear order, loaded through the second strobe
    for (int s = 0; s < 4; s++) begin
      cyc(1'b1, 1'b0, 1'b1, 1'b1, AW'(17'h0C3A0 | s), "R2");
      for (int k = 0; k < 5; k++) cyc(1'b1, 1'b1, 1'b0, 1'b1, '0, k == 3 ? "R8" : "R5");
    end
    // R6: load with the advance low
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 17'h12346, "R6");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 17'h00003, "R6");
    // R2: both strobes at once
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 17'h1FFFD, "R2");
    // R7: order flips mid-burst
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 17'h00002, "R2");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 17'h00000, "R7");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 17'h00000, "R7");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 17'h00003, "R2");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 17'h00000, "R7");
    // R3 and R9: idle cycles with a changing address
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 17'h1FFFF, "R3");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 17'h0AAAA, "R9");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 17'h15555, "R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      bit sa, sb, adv, lin;
      string req;
      r   = $urandom;
      sa  = (r[3:0] != 0);
      sb  = (r[7:4] != 0);
      adv = r[8] & r[9];
      lin = r[10];
      if (!sa || !sb)  req = adv ? "R2" : "R6";
      else if (adv)    req = "R3";
      else             req = m_lin ? "R5" : "R4";
      cyc(sa, sb, adv, lin, AW'($urandom), req);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule